// File: doc/BRIEF.md
# Two-Level Cache Tag Model with Non-Temporal Bypass

This block holds the tag and state arrays for a small first-level cache backed by a larger second-level cache. Both levels are fully associative and replace their least recently used entry. It keeps no data. Each request carries a line address and a kind: a normal load, a normal prefetch or a non-temporal prefetch. For each request the block reports whether it hit in the first level, in the second level, or in neither.

When a request misses both levels, the block asks memory for the line on a single-pulse request port. It waits for the completion pulse, and then installs the line in the first level. The two levels are exclusive: a line sits in at most one of them. A second-level hit moves the line up into the first level. The first-level victim then takes the freed second-level slot. When a first-level line arrived through a non-temporal prefetch, it carries a marker. On eviction, a marked line is discarded rather than written into the second level. Streaming data fetched this way therefore never pushes useful lines out of the larger level.

Only one request is in flight at a time. Four event counters give hit and miss totals per level, so miss ratios can be compared against a model.

Top module: `nt_cache_tags`

## Requirements
- R1: `req_ready_o` is high only when no request is being processed. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high, and nothing else is accepted until its response has been given.
- R2: A request whose line is in the first level responds with the first-level hit flag set and the second-level flag clear. It issues no memory request, and the line becomes most recently used.
- R3: A request that misses the first level but hits the second responds with only the second-level flag set and issues no memory request. The line is removed from the second level and placed in the first level.
- R4: A request that misses both levels issues exactly one single-cycle `mem_req_o` pulse carrying the request's line address. It responds with both flags clear on the cycle after `mem_rsp_i` is seen high.
- R5: Request kind encoding on `req_kind_i`: 0 is a load, 1 is a prefetch, 2 is a non-temporal prefetch. A line installed in the first level by kind 2 carries the non-temporal marker; a line installed by kind 0 or 1 does not.
- R6: A first-level victim carrying the marker is discarded and not placed in the second level, so a later request for that line misses both levels.
- R7: A first-level victim without the marker is placed in the second level as its most recently used entry. When the second level is full, this displaces its least recently used line.
- R8: When the first level is full, an install evicts its least recently used line. Recency is updated by every hit and install.
- R9: A hit in the first level, of any kind, leaves that line's marker unchanged. In particular, a non-temporal prefetch that hits causes no fetch.
- R10: `l1_hit_cnt_o`, `l1_miss_cnt_o`, `l2_hit_cnt_o` and `l2_miss_cnt_o` each count one per matching outcome. The second level is counted only for requests that missed the first. Each counter is updated by the time the response is visible.
- R11: On a second-level hit, the marker of the line moved into the first level follows the kind of the request that moved it.
- R12: Reset empties both levels, clears all counters and leaves the block ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | ADDR_W | Line address of the request |
| req_kind_i | input | 2 | Request kind (0 load, 1 prefetch, 2 non-temporal prefetch) |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_l1_hit_o | output | 1 | Request hit the first level |
| rsp_l2_hit_o | output | 1 | Request missed the first level and hit the second |
| mem_req_o | output | 1 | One-cycle fetch request |
| mem_addr_o | output | ADDR_W | Line address to fetch |
| mem_rsp_i | input | 1 | Fetch completion pulse |
| l1_hit_cnt_o | output | CNT_W | First-level hit count |
| l1_miss_cnt_o | output | CNT_W | First-level miss count |
| l2_hit_cnt_o | output | CNT_W | Second-level hit count |
| l2_miss_cnt_o | output | CNT_W | Second-level miss count |

## Verification
The bench builds the block with two first-level ways and four second-level ways and a 16-bit line address. With these sizes, every first-level install after the second evicts a line, and the second level fills and starts displacing its oldest line within a dozen requests. A short request sequence therefore reaches each interesting path:
- a marked victim being dropped,
- an unmarked victim pushing out the second level's oldest line,
- a swap between the levels after a second-level hit,
- a marker surviving hits until its line is evicted.

// File: rtl/nt_cache_pkg.sv
package nt_cache_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_PF    = 2'd1,
    KIND_PF_NT = 2'd2,
    KIND_RSVD  = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_TOUCH = 2'd1,
    OP_FILL  = 2'd2,
    OP_DROP  = 2'd3
  } tag_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_MREQ = 2'd2,
    ST_WAIT = 2'd3
  } ctl_state_e;

  localparam int NUM_EVT = 4;
  localparam int EVT_L1_HIT  = 0;
  localparam int EVT_L1_MISS = 1;
  localparam int EVT_L2_HIT  = 2;
  localparam int EVT_L2_MISS = 3;

endpackage

// File: rtl/nt_lru_tags.sv
module nt_lru_tags
  import nt_cache_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_way_o,
  output logic             vic_valid_o,
  output logic [IDX_W-1:0] vic_way_o,
  output logic [TAG_W-1:0] vic_tag_o,
  output logic             vic_nt_o,
  input  tag_op_e          op_i,
  input  logic [IDX_W-1:0] op_way_i,
  input  logic [TAG_W-1:0] op_tag_i,
  input  logic             op_nt_i
);

  localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(WAYS - 1);

  logic             valid_q [WAYS];
  logic             nt_q    [WAYS];
  logic [TAG_W-1:0] tag_q   [WAYS];
  logic [IDX_W-1:0] age_q   [WAYS];

  logic [WAYS-1:0]  hit_vec;
  logic [IDX_W-1:0] tgt_age;
  logic             free_found;

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = valid_q[w] && (tag_q[w] == lk_tag_i);
      if (hit_vec[w]) hit_way_o = IDX_W'(w);
    end
    hit_o = |hit_vec;
  end

  // empty ways first, then the oldest
  always_comb begin
    free_found = 1'b0;
    vic_way_o  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_q[w] && !free_found) begin
        vic_way_o  = IDX_W'(w);
        free_found = 1'b1;
      end
    end
    if (!free_found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[w] == AGE_MAX) vic_way_o = IDX_W'(w);
      end
    end
    vic_valid_o = valid_q[vic_way_o];
    vic_tag_o   = tag_q[vic_way_o];
    vic_nt_o    = nt_q[vic_way_o];
  end

  assign tgt_age = age_q[op_way_i];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic is_tgt;
    assign is_tgt = (op_way_i == IDX_W'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[w] <= 1'b0;
        nt_q[w]    <= 1'b0;
        tag_q[w]   <= '0;
        age_q[w]   <= IDX_W'(w);
      end else begin
        unique case (op_i)
          OP_TOUCH, OP_FILL: begin
            if (is_tgt) begin
              age_q[w] <= '0;
              if (op_i == OP_FILL) begin
                valid_q[w] <= 1'b1;
                tag_q[w]   <= op_tag_i;
                nt_q[w]    <= op_nt_i;
              end
            end else if (age_q[w] < tgt_age) begin
              age_q[w] <= age_q[w] + 1'b1;
            end
          end
          OP_DROP: begin
            if (is_tgt) begin
              age_q[w]   <= AGE_MAX;
              valid_q[w] <= 1'b0;
              nt_q[w]    <= 1'b0;
            end else if (age_q[w] > tgt_age) begin
              age_q[w] <= age_q[w] - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic [WAYS-1:0] age_seen;
  always_comb begin
    age_seen = '0;
    for (int w = 0; w < WAYS; w++) age_seen[age_q[w]] = 1'b1;
  end

  AST_TAG_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec)); // R3
  AST_AGE_PERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_seen == {WAYS{1'b1}}); // R8
  AST_FILL_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_FILL) |=> hit_o || (lk_tag_i != $past(op_tag_i)) || !$stable(lk_tag_i)); // R7

endmodule

// File: rtl/nt_evt_cnt.sv
module nt_evt_cnt #(
  parameter int N     = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     inc_i,
  output logic [CNT_W-1:0] cnt_o [N]
);

  for (genvar k = 0; k < N; k++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (inc_i[k]) cnt_q <= cnt_q + 1'b1;
    end
    assign cnt_o[k] = cnt_q;
  end

endmodule

// File: rtl/nt_ctl.sv
module nt_ctl
  import nt_cache_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int L1_IDXW = 2,
  parameter int L2_IDXW = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [1:0]         req_kind_i,
  output logic               rsp_valid_o,
  output logic               rsp_l1_hit_o,
  output logic               rsp_l2_hit_o,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic               mem_rsp_i,
  output logic [ADDR_W-1:0]  lk_tag_o,
  input  logic               l1_hit_i,
  input  logic [L1_IDXW-1:0] l1_hit_way_i,
  input  logic               l1_vic_valid_i,
  input  logic [L1_IDXW-1:0] l1_vic_way_i,
  input  logic [ADDR_W-1:0]  l1_vic_tag_i,
  input  logic               l1_vic_nt_i,
  output tag_op_e            l1_op_o,
  output logic [L1_IDXW-1:0] l1_op_way_o,
  output logic               l1_op_nt_o,
  input  logic               l2_hit_i,
  input  logic [L2_IDXW-1:0] l2_hit_way_i,
  input  logic               l2_vic_valid_i,
  input  logic [L2_IDXW-1:0] l2_vic_way_i,
  input  logic [ADDR_W-1:0]  l2_vic_tag_i,
  input  logic               l2_vic_nt_i,
  output tag_op_e            l2_op_o,
  output logic [L2_IDXW-1:0] l2_op_way_o,
  output logic [ADDR_W-1:0]  l2_op_tag_o,
  output logic [NUM_EVT-1:0] evt_o
);

  ctl_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              nt_q;
  logic              rsp_v_d, rsp_l1_d, rsp_l2_d;
  logic              spill;

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_MREQ);
  assign mem_addr_o  = addr_q;
  assign lk_tag_o    = addr_q;
  assign l1_op_nt_o  = nt_q;
  assign l2_op_tag_o = l1_vic_tag_i;
  // only unmarked, occupied victims go down a level
  assign spill       = l1_vic_valid_i && !l1_vic_nt_i;

  always_comb begin
    state_d     = state_q;
    rsp_v_d     = 1'b0;
    rsp_l1_d    = 1'b0;
    rsp_l2_d    = 1'b0;
    l1_op_o     = OP_NONE;
    l1_op_way_o = l1_vic_way_i;
    l2_op_o     = OP_NONE;
    l2_op_way_o = l2_vic_way_i;
    evt_o       = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) state_d = ST_LOOK;
      ST_LOOK: begin
        if (l1_hit_i) begin
          l1_op_o            = OP_TOUCH;
          l1_op_way_o        = l1_hit_way_i;
          evt_o[EVT_L1_HIT]  = 1'b1;
          rsp_v_d            = 1'b1;
          rsp_l1_d           = 1'b1;
          state_d            = ST_IDLE;
        end else if (l2_hit_i) begin
          evt_o[EVT_L1_MISS] = 1'b1;
          evt_o[EVT_L2_HIT]  = 1'b1;
          l1_op_o            = OP_FILL;
          l2_op_way_o        = l2_hit_way_i;
          l2_op_o            = spill ? OP_FILL : OP_DROP;
          rsp_v_d            = 1'b1;
          rsp_l2_d           = 1'b1;
          state_d            = ST_IDLE;
        end else begin
          evt_o[EVT_L1_MISS] = 1'b1;
          evt_o[EVT_L2_MISS] = 1'b1;
          state_d            = ST_MREQ;
        end
      end
      ST_MREQ: state_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rsp_i) begin
          l1_op_o = OP_FILL;
          if (spill) l2_op_o = OP_FILL;
          rsp_v_d = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      nt_q         <= 1'b0;
      rsp_valid_o  <= 1'b0;
      rsp_l1_hit_o <= 1'b0;
      rsp_l2_hit_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      rsp_valid_o  <= rsp_v_d;
      rsp_l1_hit_o <= rsp_l1_d;
      rsp_l2_hit_o <= rsp_l2_d;
      if (req_valid_i && req_ready_o) begin
        addr_q <= req_addr_i;
        nt_q   <= (req_kind_i == KIND_PF_NT);
      end
    end
  end

  AST_RSP_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o); // R1
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> $stable(addr_q)); // R1
  AST_HIT_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !(rsp_l1_hit_o && rsp_l2_hit_o)); // R2
  AST_MEM_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o && !rsp_valid_o); // R4
  AST_MISS_NOT_IN_L2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && l2_vic_valid_i) |-> l2_vic_tag_i != addr_q); // R3
  AST_L2_NO_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_vic_valid_i |-> !l2_vic_nt_i); // R6
  AST_NT_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1_op_o == OP_FILL && l1_vic_valid_i && l1_vic_nt_i) |-> l2_op_o != OP_FILL); // R6

endmodule

// File: rtl/nt_cache_tags.sv
module nt_cache_tags
  import nt_cache_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int L1_WAYS  = 4,
  parameter int L2_WAYS  = 16,
  parameter int CNT_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_kind_i,
  output logic              rsp_valid_o,
  output logic              rsp_l1_hit_o,
  output logic              rsp_l2_hit_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rsp_i,
  output logic [CNT_W-1:0]  l1_hit_cnt_o,
  output logic [CNT_W-1:0]  l1_miss_cnt_o,
  output logic [CNT_W-1:0]  l2_hit_cnt_o,
  output logic [CNT_W-1:0]  l2_miss_cnt_o
);

  localparam int L1_IDXW = (L1_WAYS > 1) ? $clog2(L1_WAYS) : 1;
  localparam int L2_IDXW = (L2_WAYS > 1) ? $clog2(L2_WAYS) : 1;

  logic [ADDR_W-1:0]  lk_tag;
  logic               l1_hit, l1_vic_valid, l1_vic_nt, l1_op_nt;
  logic [L1_IDXW-1:0] l1_hit_way, l1_vic_way, l1_op_way;
  logic [ADDR_W-1:0]  l1_vic_tag;
  tag_op_e            l1_op;
  logic               l2_hit, l2_vic_valid, l2_vic_nt;
  logic [L2_IDXW-1:0] l2_hit_way, l2_vic_way, l2_op_way;
  logic [ADDR_W-1:0]  l2_vic_tag, l2_op_tag;
  tag_op_e            l2_op;
  logic [NUM_EVT-1:0] evt;
  logic [CNT_W-1:0]   cnt [NUM_EVT];

  nt_ctl #(.ADDR_W(ADDR_W), .L1_IDXW(L1_IDXW), .L2_IDXW(L2_IDXW)) u_ctl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_addr_i, .req_kind_i,
    .rsp_valid_o, .rsp_l1_hit_o, .rsp_l2_hit_o,
    .mem_req_o, .mem_addr_o, .mem_rsp_i,
    .lk_tag_o       (lk_tag),
    .l1_hit_i       (l1_hit),
    .l1_hit_way_i   (l1_hit_way),
    .l1_vic_valid_i (l1_vic_valid),
    .l1_vic_way_i   (l1_vic_way),
    .l1_vic_tag_i   (l1_vic_tag),
    .l1_vic_nt_i    (l1_vic_nt),
    .l1_op_o        (l1_op),
    .l1_op_way_o    (l1_op_way),
    .l1_op_nt_o     (l1_op_nt),
    .l2_hit_i       (l2_hit),
    .l2_hit_way_i   (l2_hit_way),
    .l2_vic_valid_i (l2_vic_valid),
    .l2_vic_way_i   (l2_vic_way),
    .l2_vic_tag_i   (l2_vic_tag),
    .l2_vic_nt_i    (l2_vic_nt),
    .l2_op_o        (l2_op),
    .l2_op_way_o    (l2_op_way),
    .l2_op_tag_o    (l2_op_tag),
    .evt_o          (evt)
  );

  nt_lru_tags #(.WAYS(L1_WAYS), .TAG_W(ADDR_W)) u_l1 (
    .clk_i, .rst_ni,
    .lk_tag_i    (lk_tag),
    .hit_o       (l1_hit),
    .hit_way_o   (l1_hit_way),
    .vic_valid_o (l1_vic_valid),
    .vic_way_o   (l1_vic_way),
    .vic_tag_o   (l1_vic_tag),
    .vic_nt_o    (l1_vic_nt),
    .op_i        (l1_op),
    .op_way_i    (l1_op_way),
    .op_tag_i    (lk_tag),
    .op_nt_i     (l1_op_nt)
  );

  nt_lru_tags #(.WAYS(L2_WAYS), .TAG_W(ADDR_W)) u_l2 (
    .clk_i, .rst_ni,
    .lk_tag_i    (lk_tag),
    .hit_o       (l2_hit),
    .hit_way_o   (l2_hit_way),
    .vic_valid_o (l2_vic_valid),
    .vic_way_o   (l2_vic_way),
    .vic_tag_o   (l2_vic_tag),
    .vic_nt_o    (l2_vic_nt),
    .op_i        (l2_op),
    .op_way_i    (l2_op_way),
    .op_tag_i    (l2_op_tag),
    .op_nt_i     (1'b0)
  );

  nt_evt_cnt #(.N(NUM_EVT), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .inc_i (evt),
    .cnt_o (cnt)
  );

  assign l1_hit_cnt_o  = cnt[EVT_L1_HIT];
  assign l1_miss_cnt_o = cnt[EVT_L1_MISS];
  assign l2_hit_cnt_o  = cnt[EVT_L2_HIT];
  assign l2_miss_cnt_o = cnt[EVT_L2_MISS];

  AST_L2_ONLY_ON_L1_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l2_hit_cnt_o != $past(l2_hit_cnt_o)) |-> (l1_miss_cnt_o != $past(l1_miss_cnt_o))); // R10

endmodule

// File: tb/sim_nt_cache_tags.sv
module sim_nt_cache_tags;

  localparam int AW = 16;
  localparam int CW = 16;
  localparam int NV = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_kind = '0;
  logic          rsp_valid, rsp_l1, rsp_l2;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_rsp = 1'b0;
  logic [CW-1:0] c_l1h, c_l1m, c_l2h, c_l2m;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  nt_cache_tags #(.ADDR_W(AW), .L1_WAYS(2), .L2_WAYS(4), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_kind_i(req_kind),
    .rsp_valid_o(rsp_valid), .rsp_l1_hit_o(rsp_l1), .rsp_l2_hit_o(rsp_l2),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rsp_i(mem_rsp),
    .l1_hit_cnt_o(c_l1h), .l1_miss_cnt_o(c_l1m),
    .l2_hit_cnt_o(c_l2h), .l2_miss_cnt_o(c_l2m)
  );

  // {addr, kind, exp_l1_hit, exp_l2_hit, exp_fetch}; two L1 ways, four L2 ways
  localparam logic [20:0] VEC [NV] = '{
    {16'h00A0, 2'd0, 3'b001}, // R4 cold miss
    {16'h00A0, 2'd0, 3'b100}, // R2
    {16'h00B0, 2'd0, 3'b001},
    {16'h00C0, 2'd0, 3'b001}, // R7 A spills to L2
    {16'h00A0, 2'd0, 3'b010}, // R3 swap with B
    {16'h00D0, 2'd2, 3'b001}, // R5 marked fill
    {16'h00E0, 2'd0, 3'b001},
    {16'h00F0, 2'd0, 3'b001}, // R6 D dropped
    {16'h00D0, 2'd0, 3'b001}, // R6 D absent from L2
    {16'h01A0, 2'd0, 3'b001}, // R7 displaces B
    {16'h00B0, 2'd0, 3'b001}, // R7 B gone
    {16'h00A0, 2'd2, 3'b010}, // R11 moved up, marked
    {16'h00A0, 2'd2, 3'b100}, // R9 no fetch
    {16'h00A0, 2'd0, 3'b100}, // R9 marker kept
    {16'h01B0, 2'd0, 3'b001},
    {16'h01C0, 2'd0, 3'b001}, // R6 A dropped
    {16'h00A0, 2'd0, 3'b001}, // R9 proves marker survived hits
    {16'h00B0, 2'd1, 3'b010}, // R11 moved up, unmarked
    {16'h00A0, 2'd0, 3'b100}, // R8 touch
    {16'h01D0, 2'd0, 3'b001}, // R8 B evicted, not A
    {16'h00A0, 2'd0, 3'b100}, // R8
    {16'h00B0, 2'd0, 3'b010}  // R7 B was unmarked
  };

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_req(input logic [AW-1:0] a, output logic l1, output logic l2,
                            output int fetches, output logic [AW-1:0] fa, output int busy_bad);
    int dly = -1;
    fetches = 0; fa = '0; busy_bad = 0; l1 = 1'b0; l2 = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      mem_rsp = 1'b0;
      if (rsp_valid) begin
        l1 = rsp_l1; l2 = rsp_l2;
        break;
      end
      if (req_ready) busy_bad++;
      if (mem_req) begin
        fetches++;
        fa = mem_addr;
        dly = 2;
      end else if (dly > 0) begin
        dly--;
        if (dly == 0) mem_rsp = 1'b1;
      end
    end
    if (a == '1) fa = fa;
  endtask

  task automatic run_req(input logic [AW-1:0] a, input logic [1:0] k, output logic l1,
                         output logic l2, output int f, output logic [AW-1:0] fa, output int bb);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_kind = k;
    @(negedge clk);
    req_valid = 1'b0;
    finish_req(a, l1, l2, f, fa, bb);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic l1, l2;
    logic [AW-1:0] fa;
    int f, bb;

    repeat (3) @(negedge clk);
    chk("R12", int'(req_ready), 1, "ready in reset");
    chk("R12", int'(rsp_valid), 0, "rsp in reset");
    chk("R12", int'(mem_req), 0, "mem_req in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", int'(c_l1h) + int'(c_l1m) + int'(c_l2h) + int'(c_l2m), 0, "counters after reset");
    chk("R1", int'(req_ready), 1, "ready idle");

    for (int v = 0; v < NV; v++) begin
      logic [AW-1:0] a;
      a = VEC[v][20:5];
      run_req(a, VEC[v][4:3], l1, l2, f, fa, bb);
      chk($sformatf("R2 R3 v%0d", v), int'(l1), int'(VEC[v][2]), "l1 hit");
      chk($sformatf("R3 R4 v%0d", v), int'(l2), int'(VEC[v][1]), "l2 hit");
      chk($sformatf("R4 R9 v%0d", v), f, int'(VEC[v][0]), "fetch count");
      if (VEC[v][0]) chk($sformatf("R4 v%0d", v), int'(fa), int'(a), "fetch addr");
      chk($sformatf("R1 v%0d", v), bb, 0, "ready while busy");
    end

    chk("R10", int'(c_l1h), 5, "l1 hits");
    chk("R10", int'(c_l1m), 17, "l1 misses");
    chk("R10", int'(c_l2h), 4, "l2 hits");
    chk("R10", int'(c_l2m), 13, "l2 misses");

    // R1: second request held valid during the first one's fill
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h02A0; req_kind = 2'd0;
    @(negedge clk);
    req_addr = 16'h02B0;
    finish_req(16'h02A0, l1, l2, f, fa, bb);
    chk("R1", bb, 0, "stall while fill pending");
    chk("R1", int'(fa), 16'h02A0, "first fetch addr");
    chk("R1", f, 1, "one fetch for first");
    @(negedge clk);
    req_valid = 1'b0;
    finish_req(16'h02B0, l1, l2, f, fa, bb);
    chk("R1", int'(fa), 16'h02B0, "held request taken after");
    chk("R1", f, 1, "one fetch for second");
    chk("R10", int'(c_l1m), 19, "l1 misses after stall pair");

    // R12: reset empties tags and counters
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", int'(c_l1m), 0, "l1 miss cnt cleared");
    chk("R12", int'(req_ready), 1, "ready after reset");
    run_req(16'h02B0, 2'd0, l1, l2, f, fa, bb);
    chk("R12", int'(l1) + int'(l2), 0, "line gone after reset");
    chk("R12", f, 1, "refetch after reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule